// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter

This block sits behind the low-power bus comparator of a CAN transceiver and decides what the receive-data pin shows. The controller selects the mode with a standby input. Outside standby the pin mirrors the bus: low while the bus is dominant and high while it is recessive. In standby the pin stays high until the bus has been dominant for a programmable number of clock cycles. At that point the pin goes low to request a wake-up, and it stays low until the bus returns to recessive.

The standby input may be raised while the bus is already dominant, for example when the bus is stuck by a fault. In that case the block holds back every wake-up request until the bus has been recessive without a break for a second programmable interval. A flag from the I/O-supply monitor reports undervoltage. While that flag is low, the pin is released to high impedance and no wake-up gets through. The raw comparator flag is resynchronised through two flops before any decision is made. Both intervals are parameters given in clock cycles. At a 50 MHz clock the defaults of 100 and 150 cycles give 2 µs and 3 µs.

Top module: `stby_wake_filter`

## Requirements
- R1: Outside standby, with the supply good, `rx_out` is the inverse of the synchronised bus flag. It is 0 while dominant and 1 while recessive, including straight out of reset.
- R2: In standby, `rx_out` goes to 0 once the filter has seen `FILT_CYC` consecutive synchronised dominant samples. If `bus_dom_raw` rises just after a clock edge, `rx_out` is still 1 after `FILT_CYC+1` edges and is 0 after `FILT_CYC+2` edges. It then stays 0 while the bus stays dominant.
- R3: In standby, a dominant run shorter than `FILT_CYC` samples leaves `rx_out` at 1. A single recessive sample restarts the count, so two short runs separated by one recessive sample also produce no wake-up.
- R4: If standby begins (or the supply recovers in standby) while the synchronised bus flag is dominant, the block enters lockout. In lockout `rx_out` stays 1 however long the bus stays dominant.
- R5: Lockout ends after `CLR_CYC` consecutive recessive samples. From then on a dominant run is filtered as in R2, with the same `FILT_CYC+2` edge timing.
- R6: A recessive interval of `CLR_CYC-1` samples does not end the lockout. A dominant sample after it restarts the recessive count.
- R7: While `vio_good` is 0, `rx_oe` is 0 (pin released) and `rx_out` is 1. The filter state is discarded. When the supply returns in standby with the bus dominant, the block enters lockout as in R4.
- R8: After a wake-up, `rx_out` returns to 1 on the third edge after `bus_dom_raw` falls. A later dominant run of `FILT_CYC` samples raises a new wake-up.
- R9: `bus_dom_raw` passes through two flops. Outside standby a change reaches `rx_out` after exactly two clock edges.
- R10: When standby is dropped, `rx_out` mirrors the bus in the same cycle, even from lockout. The wake-up and lockout conditions are cleared at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_dom_raw | input | 1 | Unsynchronised comparator flag, 1 = bus dominant |
| stby_sel | input | 1 | 1 = standby (filtered wake-up), 0 = normal mirroring |
| vio_good | input | 1 | 1 = I/O supply above its undervoltage threshold |
| rx_out | output | 1 | Receive-data level, 0 = dominant or wake-up request |
| rx_oe | output | 1 | Pin drive enable, 0 = high impedance |

## Verification
The bench places dominant edges so that the wake-up must appear on exactly the (`FILT_CYC+2`)th edge. A filter that is off by one samples would show the low level one edge early or late. It sends runs of `FILT_CYC-1` samples, alone and split by one recessive sample. A counter that does not restart, or that accumulates across gaps, would raise a false wake-up. It enters standby with the bus already dominant and then offers a recessive gap one sample short of `CLR_CYC`. A design that skipped the lockout, or released it too early, would pull `rx_out` low. It also drops the supply and restores it with the bus dominant. A design that kept stale state across the undervoltage would drive the pin or wake at once.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  // Filter condition seen by the receive-pin stage.
  typedef enum logic [1:0] {
    WK_ACTIVE = 2'd0,  // normal mode or supply bad: no standby decision held
    WK_ARMED  = 2'd1,  // standby, counting a dominant run
    WK_WAKE   = 2'd2,  // standby, wake-up request asserted
    WK_LOCKED = 2'd3   // standby entered on a dominant bus, waiting for recessive
  } wk_state_e;
endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/wkf_run_cnt.sv
module wkf_run_cnt #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,    // hold at zero (counter not in use)
  input  logic cond,   // sample belongs to the run being measured
  output logic hit     // this sample completes LIMIT consecutive samples
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] TOP  = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || !cond)   cnt <= '0;
    else if (cnt != TOP)     cnt <= cnt + 1'b1;
  end

  assign hit = cond && !clr && (cnt == LAST);
endmodule

// File: rtl/wkf_ctrl.sv
module wkf_ctrl
  import wkf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stby_sel,
  input  logic vio_good,
  input  logic bus_s,
  input  logic dom_hit,
  input  logic rec_hit,
  output logic dom_clr,
  output logic rec_clr,
  output logic wake_f,
  output logic lock_f
);
  wk_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    if (!vio_good || !stby_sel) begin
      state_nx = WK_ACTIVE;
    end else begin
      unique case (state)
        WK_ACTIVE: state_nx = bus_s ? WK_LOCKED : WK_ARMED;
        WK_ARMED:  if (dom_hit) state_nx = WK_WAKE;
        WK_WAKE:   if (!bus_s)  state_nx = WK_ARMED;
        WK_LOCKED: if (rec_hit) state_nx = WK_ARMED;
        default:   state_nx = WK_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= WK_ACTIVE;
    else        state <= state_nx;
  end

  assign dom_clr = (state != WK_ARMED);
  assign rec_clr = (state != WK_LOCKED);
  assign wake_f  = (state == WK_WAKE);
  assign lock_f  = (state == WK_LOCKED);
endmodule

// File: rtl/wkf_rx_stage.sv
module wkf_rx_stage (
  input  logic vio_good,
  input  logic stby_sel,
  input  logic bus_s,
  input  logic wake_f,
  output logic rx_out,
  output logic rx_oe
);
  always_comb begin
    if (!vio_good)     rx_out = 1'b1;
    else if (stby_sel) rx_out = !wake_f;
    else               rx_out = !bus_s;
  end

  assign rx_oe = vio_good;
endmodule

// File: rtl/stby_wake_filter.sv
module stby_wake_filter #(
  parameter int FILT_CYC = 100,
  parameter int CLR_CYC  = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_dom_raw,
  input  logic stby_sel,
  input  logic vio_good,
  output logic rx_out,
  output logic rx_oe
);
  localparam int SYNC_STAGES = 2;

  logic bus_s;
  logic dom_hit, rec_hit, dom_clr, rec_clr;
  logic wake_f, lock_f;

  wkf_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(bus_dom_raw), .q_out(bus_s)
  );

  wkf_run_cnt #(.LIMIT(FILT_CYC)) dom_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(dom_clr), .cond(bus_s), .hit(dom_hit)
  );

  wkf_run_cnt #(.LIMIT(CLR_CYC)) rec_cnt_i (
    .clk(clk), .rst_n(rst_n), .clr(rec_clr), .cond(!bus_s), .hit(rec_hit)
  );

  wkf_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .stby_sel(stby_sel), .vio_good(vio_good),
    .bus_s(bus_s), .dom_hit(dom_hit), .rec_hit(rec_hit),
    .dom_clr(dom_clr), .rec_clr(rec_clr), .wake_f(wake_f), .lock_f(lock_f)
  );

  wkf_rx_stage rx_i (
    .vio_good(vio_good), .stby_sel(stby_sel), .bus_s(bus_s),
    .wake_f(wake_f), .rx_out(rx_out), .rx_oe(rx_oe)
  );
endmodule

// File: rtl/wkf_checker.sv
module wkf_checker #(
  parameter int FILT_CYC = 100,
  parameter int CLR_CYC  = 150
) (
  input logic clk,
  input logic rst_n,
  input logic bus_dom_raw,
  input logic stby_sel,
  input logic vio_good,
  input logic rx_out,
  input logic rx_oe,
  input logic bus_s,
  input logic wake_f,
  input logic lock_f
);
  localparam int SAT = ((FILT_CYC > CLR_CYC) ? FILT_CYC : CLR_CYC) + 1;
  localparam int RW  = $clog2(SAT + 1);
  localparam logic [RW-1:0] SATV = RW'(SAT);
  localparam logic [RW-1:0] FILV = RW'(FILT_CYC);
  localparam logic [RW-1:0] CLRV = RW'(CLR_CYC);

  logic [1:0]    age;
  logic [RW-1:0] dom_run, rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age     <= '0;
      dom_run <= '0;
      rec_run <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (!bus_s)               dom_run <= '0;
      else if (dom_run != SATV) dom_run <= dom_run + 1'b1;
      if (bus_s)                rec_run <= '0;
      else if (rec_run != SATV) rec_run <= rec_run + 1'b1;
    end
  end

  assert_sync_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (bus_s == $past(bus_dom_raw, 2)));

  assert_wake_dwell_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wake_f) && $past(stby_sel && vio_good)) |-> (dom_run >= FILV));

  assert_lock_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stby_sel) && vio_good && bus_s) |=> lock_f);

  assert_release_dwell_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_f) && $past(stby_sel && vio_good)) |-> (rec_run >= CLRV));

  assert_uv_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vio_good |-> (!rx_oe && rx_out));

  assert_uv_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vio_good |=> (!wake_f && !lock_f));

  assert_exit_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_sel |=> (!wake_f && !lock_f));
endmodule

bind stby_wake_filter wkf_checker #(.FILT_CYC(FILT_CYC), .CLR_CYC(CLR_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_dom_raw(bus_dom_raw), .stby_sel(stby_sel),
  .vio_good(vio_good), .rx_out(rx_out), .rx_oe(rx_oe), .bus_s(bus_s),
  .wake_f(wake_f), .lock_f(lock_f)
);

// File: tb/stby_wake_filter_tb_top.sv
`timescale 1ns/1ps
module stby_wake_filter_tb_top;
  localparam int F = 100;
  localparam int C = 150;

  logic clk = 1'b0;
  logic rst_n, bus_dom_raw, stby_sel, vio_good;
  logic rx_out, rx_oe;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stby_wake_filter #(.FILT_CYC(F), .CLR_CYC(C)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_dom_raw(bus_dom_raw), .stby_sel(stby_sel),
    .vio_good(vio_good), .rx_out(rx_out), .rx_oe(rx_oe)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // rx_out must equal exp at every one of the next n negedges.
  task automatic hold_chk(input int n, input logic exp, input string tag);
    logic seen = exp;
    for (int i = 0; i < n; i++) begin
      wait_cyc(1);
      if (rx_out !== exp) seen = rx_out;
    end
    chk(seen, exp, tag);
  endtask

  task automatic t_reset;
    chk(rx_out, 1'b1, "R1 reset level");
    chk(rx_oe, 1'b1, "R7 reset drive enable");
  endtask

  task automatic t_normal;
    bus_dom_raw = 1'b1;
    wait_cyc(1);
    chk(rx_out, 1'b1, "R9 one edge not enough");
    wait_cyc(1);
    chk(rx_out, 1'b0, "R1 dominant mirrored");
    bus_dom_raw = 1'b0;
    wait_cyc(2);
    chk(rx_out, 1'b1, "R1 recessive mirrored");
    vio_good = 1'b0;
    wait_cyc(1);
    chk(rx_oe, 1'b0, "R7 released in normal mode");
    vio_good = 1'b1;
    wait_cyc(2);
  endtask

  task automatic t_filter;
    stby_sel = 1'b1;
    wait_cyc(4);
    bus_dom_raw = 1'b1;
    hold_chk(F - 1, 1'b1, "R3 short run");
    bus_dom_raw = 1'b0;
    hold_chk(4, 1'b1, "R3 short run tail");
    bus_dom_raw = 1'b1;
    hold_chk(F - 1, 1'b1, "R3 first half");
    bus_dom_raw = 1'b0;
    wait_cyc(1);
    bus_dom_raw = 1'b1;
    hold_chk(F - 1, 1'b1, "R3 split run");
    bus_dom_raw = 1'b0;
    hold_chk(4, 1'b1, "R3 split run tail");
    bus_dom_raw = 1'b1;
    wait_cyc(F + 1);
    chk(rx_out, 1'b1, "R2 one edge before wake");
    wait_cyc(1);
    chk(rx_out, 1'b0, "R2 wake edge");
    hold_chk(20, 1'b0, "R2 wake held");
    bus_dom_raw = 1'b0;
    wait_cyc(2);
    chk(rx_out, 1'b0, "R8 release lag");
    wait_cyc(1);
    chk(rx_out, 1'b1, "R8 release");
    wait_cyc(2);
    bus_dom_raw = 1'b1;
    wait_cyc(F + 2);
    chk(rx_out, 1'b0, "R8 second wake");
    bus_dom_raw = 1'b0;
    wait_cyc(5);
  endtask

  task automatic t_lock;
    stby_sel = 1'b0;
    bus_dom_raw = 1'b1;
    wait_cyc(3);
    stby_sel = 1'b1;
    hold_chk(3 * F, 1'b1, "R4 stuck dominant locked");
    bus_dom_raw = 1'b0;
    wait_cyc(C - 1);
    bus_dom_raw = 1'b1;
    hold_chk(2 * F, 1'b1, "R6 short recessive keeps lock");
    bus_dom_raw = 1'b0;
    wait_cyc(C);
    bus_dom_raw = 1'b1;
    wait_cyc(F + 1);
    chk(rx_out, 1'b1, "R5 one edge before wake");
    wait_cyc(1);
    chk(rx_out, 1'b0, "R5 wake after release");
    bus_dom_raw = 1'b0;
    wait_cyc(4);
  endtask

  task automatic t_exit;
    stby_sel = 1'b0;
    bus_dom_raw = 1'b1;
    wait_cyc(3);
    stby_sel = 1'b1;
    wait_cyc(5);
    chk(rx_out, 1'b1, "R4 lock on entry");
    stby_sel = 1'b0;
    wait_cyc(1);
    chk(rx_out, 1'b0, "R10 exit mirrors bus");
    bus_dom_raw = 1'b0;
    wait_cyc(3);
  endtask

  task automatic t_uv;
    logic oe_seen = 1'b0;
    logic rx_seen = 1'b1;
    stby_sel = 1'b1;
    wait_cyc(4);
    vio_good = 1'b0;
    bus_dom_raw = 1'b1;
    for (int i = 0; i < 3 * F; i++) begin
      wait_cyc(1);
      if (rx_oe !== 1'b0) oe_seen = rx_oe;
      if (rx_out !== 1'b1) rx_seen = rx_out;
    end
    chk(oe_seen, 1'b0, "R7 pin released");
    chk(rx_seen, 1'b1, "R7 no wake in undervoltage");
    vio_good = 1'b1;
    hold_chk(2 * F, 1'b1, "R7 recovery on dominant locks");
    chk(rx_oe, 1'b1, "R7 drive restored");
    bus_dom_raw = 1'b0;
    wait_cyc(C + 2);
    bus_dom_raw = 1'b1;
    wait_cyc(F + 2);
    chk(rx_out, 1'b0, "R7 wake after recovery release");
    bus_dom_raw = 1'b0;
    wait_cyc(4);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_dom_raw = 1'b0;
    stby_sel = 1'b0;
    vio_good = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_normal();
    t_filter();
    t_lock();
    t_exit();
    t_uv();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule